// File: doc/BRIEF.md
# Multi-Cycle Eleven-Instruction Processor Core

This block is a small, non-pipelined processor core. Every instruction walks through a fixed sequence of steps. First it is fetched from a word-wide instruction port. It is then decoded and executed. Loads and stores add a memory step. Instructions that produce a register result add a write-back step. Steps that an instruction does not need are skipped, so short instructions finish in fewer cycles.

The core holds a 32-entry register file, the program counter, the instruction register and an arithmetic unit. Loads and stores go out on a data request port toward a cache or memory subsystem. The core waits in its memory step until that port reports ready. A dedicated instruction sends one-cycle enable, disable or flush commands to the data cache. A halt instruction parks the core, and only reset releases it.

Top module: `mcore_top`

## Requirements
- R1: While rst_n is low at a clock edge, the core returns to its initial state. The program counter (imem_addr) becomes 0, halted, dmem_rd, dmem_wr and cache_cmd_valid are low, and all registers read as 0.
- R2: Instruction fields are: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], a sign-extended 16-bit immediate [15:0], and a jump target [25:0]. The opcodes are ADD=1, ADDI=2, SUB=3, SLT=4, BNE=5, SW=6, LW=7, CACHE=8, J=9, JAL=10 and HALT=11. The fetch step reads the word at imem_addr and then advances imem_addr by 4.
- R3: ADD writes rs+rt to rd, SUB writes rs-rt to rd, and ADDI writes rs+imm to rt. All three wrap modulo 2^32.
- R4: SLT writes 1 to rd when rs is less than rt as a signed two's-complement value, and 0 otherwise.
- R5: LW and SW use the byte address rs+imm on dmem_addr. SW drives rt on dmem_wdata with dmem_wr high. LW drives dmem_rd high and writes dmem_rdata to rt.
- R6: While a request is pending without dmem_ready, dmem_rd, dmem_wr, dmem_addr and dmem_wdata hold steady, and the core does not advance.
- R7: BNE with rs different from rt sets the next fetch address to (address of the BNE + 4) + imm*4. Otherwise execution falls through to the next instruction.
- R8: J sets the next fetch address to target*4. JAL does the same and writes its own address + 4 into register 31.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: A CACHE instruction with immediate 0, 1 or 2 raises cache_cmd_valid for exactly one cycle (its execute step), with cache_cmd equal to that code (0 off, 1 on, 2 flush). Any other code produces no command.
- R11: Once a HALT has been decoded, halted stays high, imem_addr stays frozen, and no data or cache command is issued until reset.
- R12: With dmem_ready answering at once, BNE, J and CACHE take 3 cycles. ADD, ADDI, SUB, SLT, JAL and SW take 4 cycles, and LW takes 5 cycles. Each wait cycle on the data port adds one cycle. HALT raises halted two cycles after its fetch begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 32 | Byte address of the instruction to fetch (the program counter) |
| imem_rdata | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_rd | output | 1 | Load request |
| dmem_wr | output | 1 | Store request |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data, valid when dmem_ready is high |
| dmem_ready | input | 1 | Request completes at this clock edge |
| cache_cmd_valid | output | 1 | Cache command strobe |
| cache_cmd | output | 2 | Cache command code: 0 off, 1 on, 2 flush |
| halted | output | 1 | Core has stopped on HALT |

## Verification
Every result has its own due time, counted from the clock edge on which the instruction's fetch begins. A register result settles after 4 edges (5 for a load). A store appears on the data port after 3 edges and remains there until ready. A cache strobe is visible only between edges 2 and 3, and halted rises after edge 2. The bench checks register contents by storing them to its memory model, reading them only after halted rises. It checks the cache strobe at the exact negative edge after the second rising edge. It checks total run time against the cycle sum from R12 with zero-wait memory. It checks stall behaviour every cycle by comparing each pending request against the one from the previous cycle.

// File: rtl/mcore_pkg.sv
// Shared types for the multi-cycle core: opcodes, step states, arithmetic
// selections and the decoded control bundle. Assumes a fixed 32-bit encoding.
package mcore_pkg;

    typedef enum logic [5:0] {
        OP_NOP   = 6'd0,
        OP_ADD   = 6'd1,
        OP_ADDI  = 6'd2,
        OP_SUB   = 6'd3,
        OP_SLT   = 6'd4,
        OP_BNE   = 6'd5,
        OP_SW    = 6'd6,
        OP_LW    = 6'd7,
        OP_CACHE = 6'd8,
        OP_J     = 6'd9,
        OP_JAL   = 6'd10,
        OP_HALT  = 6'd11
    } opcode_e;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_SLT = 2'd2
    } alu_op_e;

    typedef enum logic [2:0] {
        ST_FETCH  = 3'd0,
        ST_DECODE = 3'd1,
        ST_EXEC   = 3'd2,
        ST_MEM    = 3'd3,
        ST_WB     = 3'd4,
        ST_HALT   = 3'd5
    } state_e;

    typedef struct packed {
        alu_op_e    alu_op;
        logic       use_imm;
        logic       wb_en;
        logic [4:0] dest;
        logic       is_load;
        logic       is_store;
        logic       is_bne;
        logic       is_jump;
        logic       is_link;
        logic       is_cache;
        logic       is_halt;
    } ctrl_t;

    localparam logic [4:0] LINK_REG = 5'd31;

endpackage

// File: rtl/mcore_regfile.sv
// Register file: two combinational read ports and one synchronous write port.
// Entry 0 is never written, so it always reads zero. A synchronous active-low
// reset clears every entry.
module mcore_regfile #(
    parameter int DATA_W = 32,
    parameter int REG_N  = 32,
    localparam int AW    = $clog2(REG_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     raddr_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata
);

    logic [DATA_W-1:0] regs [REG_N];

    // Clear on reset, else store one result, never into entry 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_N; i++) regs[i] <= '0;
        end else if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    // Asynchronous reads.
    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];

    // R9: entry 0 keeps zero whatever the write port does.
    a_r9_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
        regs[0] == '0);

endmodule

// File: rtl/mcore_alu.sv
// Arithmetic unit: wrapping add and subtract, and a signed less-than compare.
// Also flags operand inequality for conditional branches.
module mcore_alu
    import mcore_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y,
    output logic              neq
);

    // Select the result for the requested operation.
    always_comb begin
        unique case (op)
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(DATA_W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign neq = (a != b);

endmodule

// File: rtl/mcore_decode.sv
// Instruction decoder: splits the fixed-format word into register fields, the
// sign-extended immediate and the jump target, and builds the control bundle.
// Unknown opcodes decode to an all-zero bundle, which behaves as a no-op.
module mcore_decode
    import mcore_pkg::*;
(
    input  logic [31:0] instr,
    output ctrl_t       ctrl,
    output logic [4:0]  rs,
    output logic [4:0]  rt,
    output logic [31:0] imm_ext,
    output logic [25:0] target
);

    logic [4:0] rd;

    assign rs      = instr[25:21];
    assign rt      = instr[20:16];
    assign rd      = instr[15:11];
    assign imm_ext = {{16{instr[15]}}, instr[15:0]};
    assign target  = instr[25:0];

    // Translate the opcode into step and datapath controls.
    always_comb begin
        ctrl = '0;
        case (instr[31:26])
            OP_ADD:   begin ctrl.wb_en = 1'b1; ctrl.dest = rd; end
            OP_SUB:   begin ctrl.wb_en = 1'b1; ctrl.dest = rd; ctrl.alu_op = ALU_SUB; end
            OP_SLT:   begin ctrl.wb_en = 1'b1; ctrl.dest = rd; ctrl.alu_op = ALU_SLT; end
            OP_ADDI:  begin ctrl.wb_en = 1'b1; ctrl.dest = rt; ctrl.use_imm = 1'b1; end
            OP_LW:    begin ctrl.wb_en = 1'b1; ctrl.dest = rt; ctrl.use_imm = 1'b1;
                            ctrl.is_load = 1'b1; end
            OP_SW:    begin ctrl.use_imm = 1'b1; ctrl.is_store = 1'b1; end
            OP_BNE:   ctrl.is_bne = 1'b1;
            OP_J:     ctrl.is_jump = 1'b1;
            OP_JAL:   begin ctrl.is_jump = 1'b1; ctrl.is_link = 1'b1;
                            ctrl.wb_en = 1'b1; ctrl.dest = LINK_REG; end
            OP_CACHE: ctrl.is_cache = 1'b1;
            OP_HALT:  ctrl.is_halt = 1'b1;
            default:  ctrl = '0;
        endcase
    end

endmodule

// File: rtl/mcore_top.sv
// Multi-cycle core top: sequences fetch, decode, execute, an optional memory
// step and an optional write-back step. Assumes the instruction port answers
// combinationally and the data port completes a request on an edge where
// dmem_ready is high.
module mcore_top
    import mcore_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_N  = 32,
    localparam int AW    = $clog2(REG_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [31:0]       imem_addr,
    input  logic [31:0]       imem_rdata,
    output logic              dmem_rd,
    output logic              dmem_wr,
    output logic [DATA_W-1:0] dmem_addr,
    output logic [DATA_W-1:0] dmem_wdata,
    input  logic [DATA_W-1:0] dmem_rdata,
    input  logic              dmem_ready,
    output logic              cache_cmd_valid,
    output logic [1:0]        cache_cmd,
    output logic              halted
);

    state_e            state;
    logic [31:0]       pc, ir;
    logic [DATA_W-1:0] a_q, b_q, res_q;

    ctrl_t             ctrl;
    logic [4:0]        rs, rt;
    logic [31:0]       imm_ext;
    logic [25:0]       target;
    logic [DATA_W-1:0] rf_a, rf_b, alu_y, alu_b;
    logic              alu_neq;

    mcore_decode u_decode (
        .instr   (ir),
        .ctrl    (ctrl),
        .rs      (rs),
        .rt      (rt),
        .imm_ext (imm_ext),
        .target  (target)
    );

    mcore_regfile #(.DATA_W(DATA_W), .REG_N(REG_N)) u_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .raddr_a (rs[AW-1:0]),
        .raddr_b (rt[AW-1:0]),
        .rdata_a (rf_a),
        .rdata_b (rf_b),
        .we      (state == ST_WB && ctrl.wb_en),
        .waddr   (ctrl.dest[AW-1:0]),
        .wdata   (res_q)
    );

    assign alu_b = ctrl.use_imm ? imm_ext[DATA_W-1:0] : b_q;

    mcore_alu #(.DATA_W(DATA_W)) u_alu (
        .op  (ctrl.alu_op),
        .a   (a_q),
        .b   (alu_b),
        .y   (alu_y),
        .neq (alu_neq)
    );

    // Step sequencer and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_FETCH;
            pc    <= '0;
            ir    <= '0;
            a_q   <= '0;
            b_q   <= '0;
            res_q <= '0;
        end else begin
            unique case (state)
                ST_FETCH: begin
                    ir    <= imem_rdata;
                    pc    <= pc + 32'd4;
                    state <= ST_DECODE;
                end
                ST_DECODE: begin
                    a_q   <= rf_a;
                    b_q   <= rf_b;
                    state <= ctrl.is_halt ? ST_HALT : ST_EXEC;
                end
                ST_EXEC: begin
                    res_q <= ctrl.is_link ? pc[DATA_W-1:0] : alu_y;
                    if (ctrl.is_bne && alu_neq) pc <= pc + {imm_ext[29:0], 2'b00};
                    if (ctrl.is_jump)           pc <= {4'b0000, target, 2'b00};
                    if (ctrl.is_load || ctrl.is_store) state <= ST_MEM;
                    else if (ctrl.wb_en)              state <= ST_WB;
                    else                              state <= ST_FETCH;
                end
                ST_MEM: begin
                    if (dmem_ready) begin
                        if (ctrl.is_load) begin
                            res_q <= dmem_rdata;
                            state <= ST_WB;
                        end else begin
                            state <= ST_FETCH;
                        end
                    end
                end
                ST_WB:   state <= ST_FETCH;
                default: state <= ST_HALT;
            endcase
        end
    end

    // Port drive from the current step.
    assign imem_addr       = pc;
    assign dmem_rd         = (state == ST_MEM) && ctrl.is_load;
    assign dmem_wr         = (state == ST_MEM) && ctrl.is_store;
    assign dmem_addr       = res_q;
    assign dmem_wdata      = b_q;
    assign cache_cmd_valid = (state == ST_EXEC) && ctrl.is_cache && (imm_ext < 32'd3);
    assign cache_cmd       = imm_ext[1:0];
    assign halted          = (state == ST_HALT);

    // R6: a request waiting for ready keeps every field unchanged.
    a_r6_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        ((dmem_rd || dmem_wr) && !dmem_ready) |=>
            ($stable(dmem_addr) && $stable(dmem_wdata) && $stable(dmem_rd) && $stable(dmem_wr)));

    // R11: halt is permanent and freezes the fetch address.
    a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(imem_addr)));

    // R2: each fetch moves the fetch address on by one word.
    a_r2_fetch_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> (imem_addr == $past(imem_addr) + 32'd4));

    // R10: only codes 0..2 are ever issued, and never together with a data request.
    a_r10_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        cache_cmd_valid |-> (cache_cmd != 2'd3));

    // R5: at most one outgoing action per cycle.
    a_r5_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dmem_rd, dmem_wr, cache_cmd_valid}));

endmodule

// File: tb/mcore_top_bench.sv
// Bench for mcore_top: programs built from bench encoders, an instruction ROM
// model and a data memory model with optional random wait states.
module mcore_top_bench;

    localparam int CLK_PERIOD = 10;

    localparam logic [5:0] K_ADD = 6'd1, K_ADDI = 6'd2, K_SUB = 6'd3, K_SLT = 6'd4,
                           K_BNE = 6'd5, K_SW = 6'd6, K_LW = 6'd7, K_CACHE = 6'd8,
                           K_J = 6'd9, K_JAL = 6'd10, K_HALT = 6'd11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_rdata;
    logic        dmem_rd, dmem_wr, dmem_ready;
    logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
    logic        cache_cmd_valid;
    logic [1:0]  cache_cmd;
    logic        halted;

    logic [31:0] imem [64];
    logic [31:0] dmem [16];
    int          wait_cnt = 0;
    bit          wait_mode = 1'b0;
    logic [1:0]  clog [8];
    int          ccount;
    int          n_cmp = 0, n_bad = 0;
    int          stall_bad = 0;
    logic        prev_pend = 1'b0;
    logic [31:0] prev_addr, prev_wdata;
    logic        prev_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcore_top u_mcore_top (
        .clk             (clk),
        .rst_n           (rst_n),
        .imem_addr       (imem_addr),
        .imem_rdata      (imem_rdata),
        .dmem_rd         (dmem_rd),
        .dmem_wr         (dmem_wr),
        .dmem_addr       (dmem_addr),
        .dmem_wdata      (dmem_wdata),
        .dmem_rdata      (dmem_rdata),
        .dmem_ready      (dmem_ready),
        .cache_cmd_valid (cache_cmd_valid),
        .cache_cmd       (cache_cmd),
        .halted          (halted)
    );

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[5:2]];
    assign dmem_ready = (dmem_rd || dmem_wr) && (wait_cnt == 0);

    // Data memory model: stores on completion, then picks the next wait count.
    always @(posedge clk) begin
        if (dmem_rd || dmem_wr) begin
            if (wait_cnt == 0) begin
                if (dmem_wr) dmem[dmem_addr[5:2]] <= dmem_wdata;
                wait_cnt <= wait_mode ? int'($urandom % 4) : 0;
            end else begin
                wait_cnt <= wait_cnt - 1;
            end
        end
    end

    // Cache command log.
    always @(posedge clk) begin
        if (!rst_n) ccount <= 0;
        else if (cache_cmd_valid) begin
            if (ccount < 8) clog[ccount] <= cache_cmd;
            ccount <= ccount + 1;
        end
    end

    // R6 monitor: a pending request must look the same one cycle later.
    always @(negedge clk) begin
        if (rst_n && prev_pend) begin
            if (!(dmem_rd || dmem_wr) || dmem_rd != prev_rd ||
                dmem_addr != prev_addr || dmem_wdata != prev_wdata)
                stall_bad <= stall_bad + 1;
        end
        prev_pend  <= rst_n && (dmem_rd || dmem_wr) && !dmem_ready;
        prev_rd    <= dmem_rd;
        prev_addr  <= dmem_addr;
        prev_wdata <= dmem_wdata;
    end

    function automatic logic [31:0] enc_r(logic [5:0] op, int rs, int rt, int rd);
        return {op, rs[4:0], rt[4:0], rd[4:0], 11'd0};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, rs[4:0], rt[4:0], imm[15:0]};
    endfunction
    function automatic logic [31:0] enc_j(logic [5:0] op, int tgt);
        return {op, tgt[25:0]};
    endfunction
    function automatic logic [31:0] exp_slt(logic [31:0] a, logic [31:0] b);
        return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    endfunction
    function automatic logic [31:0] sext16(logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) imem[i] = {K_HALT, 26'd0};
        for (int i = 0; i < 16; i++) dmem[i] = 32'd0;
    endtask

    task automatic hold_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    // Release reset and run until halted; returns the edges counted.
    task automatic run_to_halt(output int cyc);
        rst_n = 1'b1;
        cyc = 0;
        do begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end while (!halted && cyc < 4000);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not end actual=running expected=done");
        finish_up();
    end

    initial begin
        int cyc;
        logic [31:0] va, vb;
        logic [15:0] im;
        void'($urandom(32'd2024));

        // ---------------- R1: reset state ----------------
        clear_mem();
        hold_reset();
        check("R1 pc", imem_addr, 32'd0);
        check("R1 halted", {31'd0, halted}, 32'd0);
        check("R1 requests", {30'd0, dmem_rd, dmem_wr}, 32'd0);
        check("R1 cache strobe", {31'd0, cache_cmd_valid}, 32'd0);

        // ---------------- R12 / R10 timing program, zero wait ----------------
        wait_mode = 1'b0;
        imem[0] = enc_i(K_CACHE, 0, 0, 1);
        imem[1] = enc_i(K_ADDI, 0, 1, 10);
        imem[2] = enc_r(K_ADD, 1, 1, 2);
        imem[3] = enc_i(K_LW, 0, 3, 0);
        imem[4] = enc_i(K_SW, 0, 2, 4);
        imem[5] = {K_HALT, 26'd0};
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R10 no strobe before execute", {31'd0, cache_cmd_valid}, 32'd0);
        @(posedge clk); @(negedge clk);
        check("R10 strobe in execute", {29'd0, cache_cmd_valid, cache_cmd}, {29'd0, 1'b1, 2'd1});
        cyc = 2;
        do begin
            @(posedge clk); cyc++; @(negedge clk);
        end while (!halted && cyc < 4000);
        check("R12 cycles to halt", cyc, 32'd22);
        check("R3 ADD result stored", dmem[1], 32'd20);
        check("R2 fetch address after halt", imem_addr, 32'd24);

        // ---------------- R3 R4 R5: arithmetic with random operands ----------------
        wait_mode = 1'b1;
        for (int it = 0; it < 12; it++) begin
            clear_mem();
            hold_reset();
            case (it)
                0:       begin va = 32'h8000_0000; vb = 32'd1; end
                1:       begin va = 32'h1234_5678; vb = 32'h1234_5678; end
                2:       begin va = 32'h7FFF_FFFF; vb = 32'hFFFF_FFFF; end
                default: begin va = $urandom; vb = $urandom; end
            endcase
            im = (it == 0) ? 16'h8000 : 16'($urandom);
            dmem[0] = va;
            dmem[1] = vb;
            imem[0]  = enc_i(K_LW, 0, 1, 0);
            imem[1]  = enc_i(K_LW, 0, 2, 4);
            imem[2]  = enc_r(K_ADD, 1, 2, 3);
            imem[3]  = enc_r(K_SUB, 1, 2, 4);
            imem[4]  = enc_r(K_SLT, 1, 2, 5);
            imem[5]  = enc_r(K_SLT, 2, 1, 6);
            imem[6]  = enc_i(K_ADDI, 1, 7, int'(im));
            imem[7]  = enc_i(K_SW, 0, 3, 8);
            imem[8]  = enc_i(K_SW, 0, 4, 12);
            imem[9]  = enc_i(K_SW, 0, 5, 16);
            imem[10] = enc_i(K_SW, 0, 6, 20);
            imem[11] = enc_i(K_SW, 0, 7, 24);
            run_to_halt(cyc);
            check("R3 ADD", dmem[2], va + vb);
            check("R3 SUB", dmem[3], va - vb);
            check("R4 SLT a<b", dmem[4], exp_slt(va, vb));
            check("R4 SLT b<a", dmem[5], exp_slt(vb, va));
            check("R3 ADDI", dmem[6], va + sext16(im));
            check("R5 loads kept", dmem[0], va);
        end

        // ---------------- R7 R8 R9 R10 R11 R5: control program ----------------
        clear_mem();
        hold_reset();
        dmem[7] = 32'hDEAD; dmem[9] = 32'hBEEF; dmem[11] = 32'h1234; dmem[15] = 32'h5555;
        imem[0]  = enc_i(K_CACHE, 0, 0, 1);
        imem[1]  = enc_i(K_ADDI, 0, 0, 7);
        imem[2]  = enc_i(K_ADDI, 0, 1, 5);
        imem[3]  = enc_i(K_ADDI, 0, 2, 5);
        imem[4]  = enc_i(K_BNE, 1, 2, 5);
        imem[5]  = enc_i(K_ADDI, 0, 3, -3);
        imem[6]  = enc_i(K_BNE, 1, 3, 1);
        imem[7]  = enc_i(K_ADDI, 0, 4, 99);
        imem[8]  = enc_j(K_JAL, 12);
        imem[9]  = enc_i(K_ADDI, 0, 4, 77);
        imem[12] = enc_i(K_CACHE, 0, 0, 0);
        imem[13] = enc_i(K_CACHE, 0, 0, 3);
        imem[14] = enc_i(K_SW, 0, 0, 28);
        imem[15] = enc_i(K_SW, 0, 3, 32);
        imem[16] = enc_i(K_SW, 0, 4, 36);
        imem[17] = enc_i(K_SW, 0, 31, 40);
        imem[18] = enc_j(K_J, 20);
        imem[19] = enc_i(K_SW, 0, 1, 44);
        imem[20] = enc_i(K_CACHE, 0, 0, 2);
        imem[21] = enc_i(K_ADDI, 0, 5, 64);
        imem[22] = enc_i(K_SW, 5, 1, -8);
        imem[23] = {K_HALT, 26'd0};
        imem[24] = enc_i(K_SW, 0, 1, 60);
        run_to_halt(cyc);
        check("R9 r0 write discarded", dmem[7], 32'd0);
        check("R7 fall-through ran", dmem[8], 32'hFFFF_FFFD);
        check("R7 taken branch skipped", dmem[9], 32'd0);
        check("R8 JAL link in r31", dmem[10], 32'd36);
        check("R8 J skipped store", dmem[11], 32'h1234);
        check("R5 negative offset store", dmem[14], 32'd5);
        check("R11 nothing after halt", dmem[15], 32'h5555);
        check("R10 command count", ccount, 32'd3);
        check("R10 first on", {30'd0, clog[0]}, 32'd1);
        check("R10 then off", {30'd0, clog[1]}, 32'd0);
        check("R10 then flush", {30'd0, clog[2]}, 32'd2);
        check("R2 fetch address at halt", imem_addr, 32'd96);

        // R11: quiet window after halt.
        begin
            int quiet_bad = 0;
            for (int k = 0; k < 40; k++) begin
                @(posedge clk); @(negedge clk);
                if (!halted || imem_addr != 32'd96 || dmem_rd || dmem_wr || cache_cmd_valid)
                    quiet_bad++;
            end
            check("R11 halt sticky and quiet", quiet_bad, 32'd0);
        end

        check("R6 pending request stable", stall_bad, 32'd0);

        // R1: reset leaves halt.
        hold_reset();
        check("R1 reset clears halt", {31'd0, halted}, 32'd0);
        check("R1 reset clears pc", imem_addr, 32'd0);

        finish_up();
    end

endmodule